// File: doc/BRIEF.md
# Mode-Selectable Ordering Store Buffer

This block sits between one core's load/store request port and a single-ported memory. Stores are parked in a small buffer and written to memory later, while loads either go straight to memory or take their data from the buffer when a parked store covers the same address. A two-bit mode input decides which reorderings are legal. Sequential mode permits none. Total-store-order lets a load overtake parked stores. Partial-store-order also lets a store reach memory ahead of an older store to a different address. A fence request waits until every earlier access has finished.

The memory side uses a request/grant pair. A request with `mem_gnt_i` high completes in that cycle: a write is performed at the closing clock edge, and read data on `mem_rdata_i` is valid in the same cycle. Each cycle, a load that needs memory takes the port ahead of draining a parked store. Load data comes back one cycle after the load is accepted.

Top module: `ordering_store_buffer`

## Requirements
- R1: After reset the buffer is empty: `req_ready_o` is high for a store, and `rsp_valid_o` and `mem_req_o` are low.
- R2: Mode encoding is 0 = sequential, 1 = total-store-order, 2 = partial-store-order, and 3 behaves as sequential. In sequential mode no request of any kind is accepted while a store is still parked, so the next operation waits until that store has been written to memory.
- R3: In total-store-order mode, a load to an address with no parked store is accepted and reads memory while older stores are still parked. Those stores are written afterwards.
- R4: In total-store-order and sequential mode, parked stores are written to memory strictly in issue order.
- R5: In partial-store-order mode, each write goes to the youngest parked store that has no older parked store to the same address. Stores to distinct addresses therefore reach memory in reverse issue order.
- R6: In partial-store-order mode, two stores to the same address still reach memory in issue order, so the younger value is the one that remains.
- R7: A load whose address matches parked stores is answered with the data of the youngest matching store. It is accepted even without a memory grant and makes no memory read.
- R8: The buffer holds 4 stores. With 4 parked, a store request sees `req_ready_o` low until a slot frees.
- R9: Opcode 2 is a fence. It is accepted only once the buffer is empty, so every earlier store is in memory before any later request is accepted.
- R10: Opcode 0 is a load and opcode 1 is a store. An accepted load raises `rsp_valid_o` for one cycle in the next cycle, with memory or forwarded data.
- R11: When two instances share one memory and run the two-flag handshake (each stores its own flag, then loads the other's), both loads see the flag still clear in total-store-order and partial-store-order mode. In sequential mode, neither load does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Ordering mode select |
| req_valid_i | input | 1 | Core request valid |
| req_ready_o | output | 1 | Request accepted this cycle when high with valid |
| req_op_i | input | 2 | 0 load, 1 store, 2 fence |
| req_addr_i | input | AW | Request address |
| req_wdata_i | input | DW | Store data |
| rsp_valid_o | output | 1 | Load data valid |
| rsp_data_o | output | DW | Load data |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory access is a write |
| mem_addr_o | output | AW | Memory address |
| mem_wdata_o | output | DW | Memory write data |
| mem_gnt_i | input | 1 | Memory accepts the access this cycle |
| mem_rdata_i | input | DW | Read data, valid in the granted cycle |

## Verification
The properties assume that `mode_i` only changes while the buffer is empty and no request is pending. They also assume that a request's fields stay steady until it is accepted. The stimulus keeps to this: it switches mode between tests, after the buffer has drained, and holds each request until the ready sample taken a quarter period after the driving edge shows acceptance. Memory grants are only switched at falling edges, so the ready output, which depends on the grant, is settled at that sample.

// File: rtl/sb_pkg.sv
package sb_pkg;
    typedef enum logic [1:0] {
        MODE_SEQ = 2'd0,
        MODE_TSO = 2'd1,
        MODE_PSO = 2'd2,
        MODE_ALT = 2'd3
    } order_mode_e;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_FENCE = 2'd2,
        OP_NONE  = 2'd3
    } req_op_e;
endpackage

// File: rtl/sb_forward.sv
module sb_forward #(
    parameter int DEPTH = 4,
    parameter int AW    = 8,
    parameter int DW    = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic [CW-1:0]              count_i,
    input  logic [DEPTH-1:0][AW-1:0]   ent_addr_i,
    input  logic [DEPTH-1:0][DW-1:0]   ent_data_i,
    input  logic [AW-1:0]              look_addr_i,
    output logic                       hit_o,
    output logic [DW-1:0]              data_o
);
    // Entries are kept oldest-first, so the last match in the scan is the youngest.
    always_comb begin
        hit_o  = 1'b0;
        data_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (i < int'(count_i) && ent_addr_i[i] == look_addr_i) begin
                hit_o  = 1'b1;
                data_o = ent_data_i[i];
            end
        end
    end
endmodule

// File: rtl/sb_drain_pick.sv
module sb_drain_pick #(
    parameter int DEPTH = 4,
    parameter int AW    = 8,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [CW-1:0]            count_i,
    input  logic [DEPTH-1:0][AW-1:0] ent_addr_i,
    input  logic                     relaxed_i,
    output logic [IW-1:0]            pick_o
);
    logic free_slot;

    // In-order modes always drain the head. The relaxed mode takes the youngest
    // entry that has no older entry to the same address.
    always_comb begin
        pick_o    = '0;
        free_slot = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            free_slot = (i < int'(count_i));
            for (int j = 0; j < DEPTH; j++) begin
                if (j < i && ent_addr_i[j] == ent_addr_i[i]) begin
                    free_slot = 1'b0;
                end
            end
            if (relaxed_i && free_slot) begin
                pick_o = IW'(i);
            end
        end
    end
endmodule

// File: rtl/ordering_store_buffer.sv
module ordering_store_buffer #(
    parameter int DEPTH = 4,
    parameter int AW    = 8,
    parameter int DW    = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode_i,
    input  logic          req_valid_i,
    output logic          req_ready_o,
    input  logic [1:0]    req_op_i,
    input  logic [AW-1:0] req_addr_i,
    input  logic [DW-1:0] req_wdata_i,
    output logic          rsp_valid_o,
    output logic [DW-1:0] rsp_data_o,
    output logic          mem_req_o,
    output logic          mem_we_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_wdata_o,
    input  logic          mem_gnt_i,
    input  logic [DW-1:0] mem_rdata_i
);
    import sb_pkg::*;

    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][AW-1:0] addr;
        logic [DEPTH-1:0][DW-1:0] data;
        logic [CW-1:0]            count;
        logic                     rsp_valid;
        logic [DW-1:0]            rsp_data;
    } sb_state_t;

    sb_state_t   st_d, st_q;
    order_mode_e mode;
    req_op_e     op;
    logic        strict_ord, relaxed_wr, buf_empty, buf_full;
    logic        fwd_hit;
    logic [DW-1:0] fwd_data;
    logic [IW-1:0] drain_idx;
    logic        load_port, drain_go, accept, push_go, load_go;

    assign mode       = order_mode_e'(mode_i);
    assign op         = req_op_e'(req_op_i);
    assign strict_ord = (mode == MODE_SEQ) || (mode == MODE_ALT);
    assign relaxed_wr = (mode == MODE_PSO);
    assign buf_empty  = (st_q.count == '0);
    assign buf_full   = (st_q.count == CW'(DEPTH));

    sb_forward #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fwd (
        .count_i     (st_q.count),
        .ent_addr_i  (st_q.addr),
        .ent_data_i  (st_q.data),
        .look_addr_i (req_addr_i),
        .hit_o       (fwd_hit),
        .data_o      (fwd_data)
    );

    sb_drain_pick #(.DEPTH(DEPTH), .AW(AW)) u_pick (
        .count_i    (st_q.count),
        .ent_addr_i (st_q.addr),
        .relaxed_i  (relaxed_wr),
        .pick_o     (drain_idx)
    );

    always_comb begin
        // request acceptance
        req_ready_o = 1'b0;
        unique case (op)
            OP_LOAD:  req_ready_o = (strict_ord ? buf_empty : 1'b1) && (fwd_hit || mem_gnt_i);
            OP_STORE: req_ready_o = strict_ord ? buf_empty : !buf_full;
            OP_FENCE: req_ready_o = buf_empty;
            default:  req_ready_o = 1'b1;
        endcase
        accept  = req_valid_i && req_ready_o;
        load_go = accept && (op == OP_LOAD);
        push_go = accept && (op == OP_STORE);

        // memory port: a missing load beats a drain
        load_port   = req_valid_i && (op == OP_LOAD) && !fwd_hit && (strict_ord ? buf_empty : 1'b1);
        mem_req_o   = load_port || !buf_empty;
        mem_we_o    = !load_port && !buf_empty;
        mem_addr_o  = load_port ? req_addr_i : st_q.addr[drain_idx];
        mem_wdata_o = st_q.data[drain_idx];
        drain_go    = mem_we_o && mem_gnt_i;

        // next state
        st_d = st_q;
        if (drain_go) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                if (i >= int'(drain_idx)) begin
                    st_d.addr[i] = st_q.addr[i+1];
                    st_d.data[i] = st_q.data[i+1];
                end
            end
            st_d.count = st_q.count - 1'b1;
        end
        if (push_go) begin
            st_d.addr[st_d.count[IW-1:0]] = req_addr_i;
            st_d.data[st_d.count[IW-1:0]] = req_wdata_i;
            st_d.count = st_d.count + 1'b1;
        end
        st_d.rsp_valid = load_go;
        if (load_go) begin
            st_d.rsp_data = fwd_hit ? fwd_data : mem_rdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid_o = st_q.rsp_valid;
    assign rsp_data_o  = st_q.rsp_data;

    // R8: occupancy never passes capacity
    a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count <= CW'(DEPTH));

    // R2: strict modes admit nothing while a store is parked
    a_r2_strict_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (strict_ord && !buf_empty) |-> !req_ready_o);

    // R3: in TSO a granted load is never held behind parked stores
    a_r3_load_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_TSO && req_valid_i && op == OP_LOAD && mem_gnt_i) |-> req_ready_o);

    // R7: a forwarded load never reads memory
    a_r7_fwd_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o && op == OP_LOAD && fwd_hit) |-> !(mem_req_o && !mem_we_o));

    // R9: a fence only passes an empty buffer
    a_r9_fence_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o && op == OP_FENCE) |-> (st_q.count == '0));

    // R10: every accepted load answers next cycle
    a_r10_rsp_next: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o && op == OP_LOAD) |=> rsp_valid_o);

    // R4: in TSO the write always comes from the oldest entry
    a_r4_tso_head: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_TSO && mem_req_o && mem_we_o) |-> (mem_addr_o == st_q.addr[0]));
endmodule

// File: tb/ordering_store_buffer_test.sv
module ordering_store_buffer_test;
    localparam int T  = 10;
    localparam int AW = 8;
    localparam int DW = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    always #(T/2) clk = ~clk;

    logic [1:0]    mode0, mode1;
    logic          v0, v1, rdy0, rdy1;
    logic [1:0]    op0, op1;
    logic [AW-1:0] a0, a1, ma0, ma1;
    logic [DW-1:0] d0, d1, wd0, wd1, rd0, rd1, rsp0, rsp1;
    logic          rv0, rv1, mr0, mr1, we0, we1;
    logic          g0, g1;

    ordering_store_buffer #(.DEPTH(4), .AW(AW), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode0), .req_valid_i(v0), .req_ready_o(rdy0),
        .req_op_i(op0), .req_addr_i(a0), .req_wdata_i(d0), .rsp_valid_o(rv0), .rsp_data_o(rsp0),
        .mem_req_o(mr0), .mem_we_o(we0), .mem_addr_o(ma0), .mem_wdata_o(wd0),
        .mem_gnt_i(g0), .mem_rdata_i(rd0));

    ordering_store_buffer #(.DEPTH(4), .AW(AW), .DW(DW)) peer (
        .clk(clk), .rst_n(rst_n), .mode_i(mode1), .req_valid_i(v1), .req_ready_o(rdy1),
        .req_op_i(op1), .req_addr_i(a1), .req_wdata_i(d1), .rsp_valid_o(rv1), .rsp_data_o(rsp1),
        .mem_req_o(mr1), .mem_we_o(we1), .mem_addr_o(ma1), .mem_wdata_o(wd1),
        .mem_gnt_i(g1), .mem_rdata_i(rd1));

    // shared memory model
    logic [DW-1:0] mem [256];
    function automatic logic [DW-1:0] base(input logic [AW-1:0] a);
        return {8'hA5, a};
    endfunction
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= base(AW'(i));
        end else begin
            if (mr0 && we0 && g0) mem[ma0] <= wd0;
            if (mr1 && we1 && g1) mem[ma1] <= wd1;
        end
    end
    assign rd0 = mem[ma0];
    assign rd1 = mem[ma1];

    int checks = 0, errors = 0;
    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // scoreboards
    logic [DW-1:0] exp0_q[$], exp1_q[$];
    string         tag0_q[$], tag1_q[$];
    logic [AW-1:0] wl_a[$];
    logic [DW-1:0] wl_d[$];

    always @(negedge clk) begin
        #(T/4);
        if (rst_n && rv0) begin
            if (exp0_q.size() == 0) check("R10 unexpected response core0", 32'(rsp0), 32'hFFFF_FFFF);
            else check(tag0_q.pop_front(), 32'(rsp0), 32'(exp0_q.pop_front()));
        end
        if (rst_n && rv1) begin
            if (exp1_q.size() == 0) check("R10 unexpected response core1", 32'(rsp1), 32'hFFFF_FFFF);
            else check(tag1_q.pop_front(), 32'(rsp1), 32'(exp1_q.pop_front()));
        end
        if (rst_n && mr0 && we0 && g0) begin
            wl_a.push_back(ma0);
            wl_d.push_back(wd0);
        end
    end

    task automatic issue(input int core, input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
        if (core == 0) begin v0 = 1'b1; op0 = op; a0 = a; d0 = d; end
        else begin v1 = 1'b1; op1 = op; a1 = a; d1 = d; end
        #(T/4);
        while ((core == 0) ? !rdy0 : !rdy1) begin
            @(negedge clk);
            #(T/4);
        end
        @(negedge clk);
        if (core == 0) v0 = 1'b0; else v1 = 1'b0;
    endtask

    task automatic load(input int core, input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag);
        if (core == 0) begin exp0_q.push_back(e); tag0_q.push_back(tag); end
        else begin exp1_q.push_back(e); tag1_q.push_back(tag); end
        issue(core, 2'd0, a, '0);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic dekker(input logic [1:0] m, input logic [AW-1:0] f0, input logic [AW-1:0] f1, input logic both);
        mode0 = m; mode1 = m; g0 = 1'b1; g1 = 1'b1;
        fork
            begin issue(0, 2'd1, f0, 16'h0001); load(0, f1, both ? base(f1) : 16'h0001, "R11 core0 flag read"); end
            begin issue(1, 2'd1, f1, 16'h0001); load(1, f0, both ? base(f0) : 16'h0001, "R11 core1 flag read"); end
        join
        idle(4);
        check("R11 both flags in memory", 32'({mem[f0], mem[f1]}), 32'h0001_0001);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        mode0 = 2'd0; mode1 = 2'd0; v0 = 0; v1 = 0; op0 = 2'd1; op1 = 2'd1;
        a0 = '0; a1 = '0; d0 = '0; d1 = '0; g0 = 1'b1; g1 = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #(T/4);
        // R1 reset state
        check("R1 ready after reset", 32'(rdy0), 32'd1);
        check("R1 rsp_valid after reset", 32'(rv0), 32'd0);
        check("R1 mem_req after reset", 32'(mr0), 32'd0);
        @(negedge clk);

        // R10 plain load
        load(0, 8'h10, base(8'h10), "R10 load data");
        idle(2);

        // R2 sequential blocks, for mode 0 and mode 3
        for (int m = 0; m < 2; m++) begin
            mode0 = (m == 0) ? 2'd0 : 2'd3;
            g0 = 1'b0;
            issue(0, 2'd1, 8'h20 + AW'(m), 16'h1110 + DW'(m));
            v0 = 1'b1; op0 = 2'd0; a0 = 8'h28;
            #(T/4);
            check("R2 load held behind parked store", 32'(rdy0), 32'd0);
            @(negedge clk);
            v0 = 1'b0; g0 = 1'b1;
            load(0, 8'h28, base(8'h28), "R2 load after drain");
            load(0, 8'h20 + AW'(m), 16'h1110 + DW'(m), "R2 store reached memory");
            idle(2);
        end

        // R3 / R4 total-store-order
        mode0 = 2'd1; g0 = 1'b0;
        wl_a.delete(); wl_d.delete();
        issue(0, 2'd1, 8'h30, 16'h3030);
        issue(0, 2'd1, 8'h31, 16'h3131);
        g0 = 1'b1;
        load(0, 8'h40, base(8'h40), "R3 load bypasses parked stores");
        check("R3 stores still parked at load", 32'(mem[8'h30]), 32'(base(8'h30)));
        idle(4);
        check("R4 write count", wl_a.size(), 2);
        if (wl_a.size() == 2) check("R4 issue order", 32'({wl_a[0], wl_a[1]}), 32'h3031);

        // R7 forwarding, R8 full
        g0 = 1'b0;
        issue(0, 2'd1, 8'h50, 16'h0001);
        issue(0, 2'd1, 8'h51, 16'h0002);
        issue(0, 2'd1, 8'h50, 16'h0003);
        load(0, 8'h50, 16'h0003, "R7 youngest match forwarded");
        load(0, 8'h51, 16'h0002, "R7 forward second address");
        issue(0, 2'd1, 8'h52, 16'h0004);
        v0 = 1'b1; op0 = 2'd1; a0 = 8'h53; d0 = 16'h0005;
        #(T/4);
        check("R8 store refused when full", 32'(rdy0), 32'd0);
        @(negedge clk);
        v0 = 1'b0; g0 = 1'b1;
        issue(0, 2'd1, 8'h53, 16'h0005);
        idle(6);
        check("R4 same address keeps younger", 32'(mem[8'h50]), 32'h0003);
        check("R8 fifth store written", 32'(mem[8'h53]), 32'h0005);

        // R5 partial-store-order, distinct addresses
        mode0 = 2'd2; g0 = 1'b0;
        wl_a.delete(); wl_d.delete();
        issue(0, 2'd1, 8'h60, 16'h000A);
        issue(0, 2'd1, 8'h61, 16'h000B);
        issue(0, 2'd1, 8'h62, 16'h000C);
        g0 = 1'b1;
        idle(5);
        check("R5 write count", wl_a.size(), 3);
        if (wl_a.size() == 3) check("R5 youngest first", 32'({wl_a[0], wl_a[1], wl_a[2]}), 32'h626160);

        // R6 partial-store-order, same address
        g0 = 1'b0;
        wl_a.delete(); wl_d.delete();
        issue(0, 2'd1, 8'h70, 16'h0001);
        issue(0, 2'd1, 8'h71, 16'h0002);
        issue(0, 2'd1, 8'h70, 16'h0003);
        g0 = 1'b1;
        idle(5);
        check("R6 write count", wl_d.size(), 3);
        if (wl_d.size() == 3) check("R6 data order", 32'({wl_d[0][3:0], wl_d[1][3:0], wl_d[2][3:0]}), 32'h213);
        check("R6 final value", 32'(mem[8'h70]), 32'h0003);

        // R9 fence
        mode0 = 2'd1; g0 = 1'b0;
        issue(0, 2'd1, 8'h80, 16'h0007);
        v0 = 1'b1; op0 = 2'd2; a0 = '0;
        #(T/4);
        check("R9 fence held while store parked", 32'(rdy0), 32'd0);
        @(negedge clk);
        v0 = 1'b0; g0 = 1'b1;
        issue(0, 2'd2, 8'h00, 16'h0000);
        check("R9 store in memory at fence", 32'(mem[8'h80]), 32'h0007);
        load(0, 8'h80, 16'h0007, "R9 load after fence");
        idle(2);

        // R11 two-flag handshake
        dekker(2'd0, 8'h90, 8'h91, 1'b0);
        dekker(2'd1, 8'hA0, 8'hA1, 1'b1);
        dekker(2'd2, 8'hB0, 8'hB1, 1'b1);
        idle(2);
        check("R10 core0 responses all seen", exp0_q.size(), 0);
        check("R11 core1 responses all seen", exp1_q.size(), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule